// File: doc/BRIEF.md
# Atomic Reservation Monitor for Linked Load and Conditional Store

This block keeps the reservation that lets a core perform an atomic read-modify-write with a pair of instructions: a linked load followed by a conditional store. The core hands each of these operations to the block over a valid/ready request channel. Each request carries a base register value, a signed offset and, for the conditional store, the store data. On a linked load the block computes the effective address and records the word it falls in as reserved. Meanwhile it snoops every write that other agents make to memory, on a parameterised number of snoop ports, and drops the reservation as soon as the reserved word is written.

On a conditional store the block decides the outcome. The store succeeds only if a reservation is still held for the same word and no other agent writes that word in the same cycle. A successful store emits a one-cycle memory write strobe with its address and data. Whatever the outcome, the block returns the result value for the store's destination register on a valid/ready response channel: 1 for success and 0 for failure.

Back-pressure rules: a request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is pending and `resp_ready` is low. A pending response holds its data unchanged until `resp_ready` takes it. Linked loads produce no response; the memory read that returns their data lies outside this block.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation is held: `resp_valid` and `mem_we` are 0, `req_ready` is 1, and a conditional store issued first fails.
- R2: A conditional store to the word reserved by the latest linked load, with no write to that word in between, succeeds. In the cycle after acceptance `resp_valid` is 1 and `resp_data` is 1, and for exactly one cycle `mem_we` is 1, with `mem_addr` equal to the effective address and `mem_wdata` equal to the store data.
- R3: A conditional store made while no reservation is held fails: `resp_data` is 0 and `mem_we` stays 0.
- R4: Only address bits [ADDR_W-1:2] are compared. A conditional store to another word fails, and one to a different byte of the reserved word succeeds.
- R5: A snoop write (`snp_we[i]` = 1) to any byte of the reserved word clears the reservation, so the next conditional store fails. A snoop write to any other word leaves the reservation intact.
- R6: Every accepted conditional store clears the reservation, whether it succeeds or fails.
- R7: When a snoop write to the word of a conditional store falls in the same cycle as that store's acceptance, the store fails.
- R8: A linked load accepted in the same cycle as a snoop write to its own word leaves no reservation.
- R9: The effective address is the base plus the sign-extended offset, taken modulo 2^ADDR_W.
- R10: While `resp_valid` is 1 and `resp_ready` is 0, `req_ready` is 0 and `resp_valid` and `resp_data` hold steady. With `req_op` equal to 0 (linked load) no response is produced; `req_op` equal to 1 selects a conditional store.
- R11: A later linked load replaces the reserved word with its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 1 | 0 = linked load, 1 = conditional store |
| req_base | input | ADDR_W | Base register value |
| req_ofs | input | OFS_W | Signed offset |
| req_wdata | input | DATA_W | Store data |
| snp_we | input | N_SNP | Per-port external write strobe |
| snp_addr | input | N_SNP*ADDR_W | External write byte addresses, port i at bits [i*ADDR_W +: ADDR_W] |
| resp_valid | output | 1 | Store result present |
| resp_ready | input | 1 | Consumer takes result |
| resp_data | output | DATA_W | 1 on success, 0 on failure |
| mem_we | output | 1 | Memory write strobe on success |
| mem_addr | output | ADDR_W | Effective address of the write |
| mem_wdata | output | DATA_W | Write data |

## Verification
The bench uses the default parameters: 32-bit addresses and data, a 16-bit offset and two snoop ports. With two ports, a snoop that hits can arrive on either port while the other port writes an unrelated word. Random traffic is confined to a window of a few words around a base address. Negative offsets are included, so effective addresses cross below the base. The narrow window makes same-word collisions between snoops, linked loads and conditional stores frequent, which reaches the same-cycle priority cases over and over.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic {
    OP_LINK_LOAD  = 1'b0,
    OP_COND_STORE = 1'b1
  } llsc_op_e;
endpackage

// File: rtl/llsc_eaddr.sv
module llsc_eaddr #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - OFS_W;
  logic [ADDR_W-1:0] ofs_ext;
  assign ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
  assign ea = base + ofs_ext;   // R9
endmodule

// File: rtl/llsc_snoop.sv
module llsc_snoop #(
  parameter int ADDR_W = 32,
  parameter int N_SNP  = 2,
  parameter int LSB    = 2
) (
  input  logic [N_SNP-1:0]        snp_we,
  input  logic [N_SNP*ADDR_W-1:0] snp_addr,
  input  logic [ADDR_W-1:0]       cmp_ea,
  input  logic [ADDR_W-1:0]       cmp_resv,
  output logic                    hit_ea,
  output logic                    hit_resv
);
  logic [N_SNP-1:0] hv_ea, hv_resv;
  for (genvar i = 0; i < N_SNP; i++) begin : g_port
    logic [ADDR_W-1:0] a;
    assign a = snp_addr[i*ADDR_W +: ADDR_W];
    assign hv_ea[i]   = snp_we[i] && (((a ^ cmp_ea)   >> LSB) == '0);
    assign hv_resv[i] = snp_we[i] && (((a ^ cmp_resv) >> LSB) == '0);
  end
  assign hit_ea   = |hv_ea;
  assign hit_resv = |hv_resv;
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int ADDR_W = 32,
  parameter int LSB    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_acc,
  input  logic              sc_acc,
  input  logic [ADDR_W-1:0] ea,
  input  logic              snp_hit_ea,
  input  logic              snp_hit_resv,
  output logic              resv_valid,
  output logic [ADDR_W-1:0] resv_addr,
  output logic              sc_ok
);
  localparam int WORD_W = ADDR_W - LSB;
  logic [WORD_W-1:0] resv_word;
  logic              same_word;

  assign resv_addr = {resv_word, {LSB{1'b0}}};
  assign same_word = ((ea ^ resv_addr) >> LSB) == '0;
  assign sc_ok     = resv_valid && same_word && !snp_hit_ea;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_word  <= '0;
    end else if (ll_acc) begin
      resv_valid <= !snp_hit_ea;
      resv_word  <= ea[ADDR_W-1:LSB];
    end else if (sc_acc || snp_hit_resv) begin
      resv_valid <= 1'b0;
    end
  end

  a_r5_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit_resv && !ll_acc) |=> !resv_valid);
  a_r6_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sc_acc |=> !resv_valid);
  a_r8_ll_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_acc && snp_hit_ea) |=> !resv_valid);
  a_r7_sc_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit_ea && sc_acc) |-> !sc_ok);
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 16,
  parameter int N_SNP  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_op,
  input  logic [ADDR_W-1:0]       req_base,
  input  logic [OFS_W-1:0]        req_ofs,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic [N_SNP-1:0]        snp_we,
  input  logic [N_SNP*ADDR_W-1:0] snp_addr,
  output logic                    resp_valid,
  input  logic                    resp_ready,
  output logic [DATA_W-1:0]       resp_data,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata
);
  import llsc_pkg::*;
  localparam int LSB = $clog2(DATA_W / 8);

  llsc_op_e          op;
  logic              acc, ll_acc, sc_acc;
  logic [ADDR_W-1:0] ea, resv_addr;
  logic              hit_ea, hit_resv, resv_valid, sc_ok;

  assign op        = llsc_op_e'(req_op);
  assign req_ready = !resp_valid || resp_ready;
  assign acc       = req_valid && req_ready;
  assign ll_acc    = acc && (op == OP_LINK_LOAD);
  assign sc_acc    = acc && (op == OP_COND_STORE);

  llsc_eaddr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ea (
    .base(req_base), .ofs(req_ofs), .ea(ea));

  llsc_snoop #(.ADDR_W(ADDR_W), .N_SNP(N_SNP), .LSB(LSB)) u_snp (
    .snp_we(snp_we), .snp_addr(snp_addr), .cmp_ea(ea), .cmp_resv(resv_addr),
    .hit_ea(hit_ea), .hit_resv(hit_resv));

  llsc_resv #(.ADDR_W(ADDR_W), .LSB(LSB)) u_resv (
    .clk(clk), .rst_n(rst_n), .ll_acc(ll_acc), .sc_acc(sc_acc), .ea(ea),
    .snp_hit_ea(hit_ea), .snp_hit_resv(hit_resv),
    .resv_valid(resv_valid), .resv_addr(resv_addr), .sc_ok(sc_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      mem_we <= sc_acc && sc_ok;
      if (sc_acc) begin
        resp_valid <= 1'b1;
        resp_data  <= DATA_W'(sc_ok);
        mem_addr   <= ea;
        mem_wdata  <= req_wdata;
      end else if (resp_ready) begin
        resp_valid <= 1'b0;
      end
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));
  a_r2_we_means_success: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (resp_valid && resp_data == DATA_W'(1)));
  a_r3_no_resv_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_acc && !resv_valid) |=> (!mem_we && resp_data == '0));
  a_r10_ll_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_acc && resp_ready) |=> !resp_valid);
endmodule

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/100ps
module sim_llsc_monitor;
  localparam int AW = 32, DW = 32, OW = 16, NS = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready, req_op = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [OW-1:0] req_ofs = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NS-1:0] snp_we = '0;
  logic [NS*AW-1:0] snp_addr = '0;
  logic          resp_valid, resp_ready = 1'b1;
  logic [DW-1:0] resp_data;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_v = 0;
  logic [AW-3:0] m_w = '0;

  always #2.5 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .OFS_W(OW), .N_SNP(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base(req_base), .req_ofs(req_ofs), .req_wdata(req_wdata),
    .snp_we(snp_we), .snp_addr(snp_addr), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_data(resp_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] eff(logic [AW-1:0] b, logic [OW-1:0] o);
    return b + {{(AW-OW){o[OW-1]}}, o};
  endfunction

  function automatic bit snp_hits(logic [AW-3:0] w, logic w0, logic [AW-1:0] a0,
                                  logic w1, logic [AW-1:0] a1);
    return (w0 && a0[AW-1:2] == w) || (w1 && a1[AW-1:2] == w);
  endfunction

  // One request with snoop traffic in the same cycle; checks outputs after the edge.
  task automatic op(string req, bit sc, logic [AW-1:0] b, logic [OW-1:0] o,
                    logic [DW-1:0] d, logic w0 = 0, logic [AW-1:0] a0 = '0,
                    logic w1 = 0, logic [AW-1:0] a1 = '0);
    logic [AW-1:0] e;
    bit hit_e, hit_r, ok;
    e = eff(b, o);
    hit_e = snp_hits(e[AW-1:2], w0, a0, w1, a1);
    hit_r = snp_hits(m_w, w0, a0, w1, a1);
    ok = sc && m_v && (m_w == e[AW-1:2]) && !hit_e;
    @(negedge clk);
    req_valid = 1; req_op = sc; req_base = b; req_ofs = o; req_wdata = d;
    snp_we = {w1, w0}; snp_addr = {a1, a0};
    @(posedge clk); #1;
    req_valid = 0; snp_we = '0;
    chk({req, " resp_valid"}, resp_valid, sc);
    chk({req, " mem_we"}, mem_we, ok);
    if (sc) chk({req, " resp_data"}, resp_data, ok);
    if (ok) begin
      chk({req, " mem_addr"}, mem_addr, e);
      chk({req, " mem_wdata"}, mem_wdata, d);
    end
    if (!sc) begin m_v = !hit_e; m_w = e[AW-1:2]; end
    else m_v = 0;
    if (!sc && hit_r && hit_e) m_v = 0;
    if (sc && hit_r) m_v = 0;
  endtask

  task automatic idle(string req, logic w0, logic [AW-1:0] a0,
                      logic w1 = 0, logic [AW-1:0] a1 = '0);
    @(negedge clk);
    snp_we = {w1, w0}; snp_addr = {a1, a0};
    @(posedge clk); #1;
    snp_we = '0;
    if (snp_hits(m_w, w0, a0, w1, a1)) m_v = 0;
    chk({req, " idle mem_we"}, mem_we, 0);
    chk({req, " idle resp_valid"}, resp_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 resp_valid", resp_valid, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 req_ready", req_ready, 1);
    op("R1 R3 first sc", 1, 32'h2000, 0, 32'hAAAA);
    op("R2 ll", 0, 32'h2000, 0, 0);
    op("R2 sc", 1, 32'h2000, 0, 32'h1111);
    op("R9 ll neg", 0, 32'h2010, 16'hFFF0, 0);
    op("R9 sc pos", 1, 32'h1FF0, 16'h0010, 32'h2222);
    op("R4 ll", 0, 32'h2000, 0, 0);
    op("R4 sc other byte", 1, 32'h2003, 0, 32'h3333);
    op("R4 ll", 0, 32'h2000, 0, 0);
    op("R4 sc other word", 1, 32'h2004, 0, 32'h4444);
    op("R5 ll", 0, 32'h2000, 0, 0);
    idle("R5 hit", 0, 0, 1, 32'h2002);
    op("R5 sc after hit", 1, 32'h2000, 0, 32'h5555);
    op("R5 ll", 0, 32'h2000, 0, 0);
    idle("R5 miss", 1, 32'h2004, 1, 32'h1FFC);
    op("R5 sc after miss", 1, 32'h2000, 0, 32'h5656);
    op("R6 ll", 0, 32'h2000, 0, 0);
    op("R6 sc ok", 1, 32'h2000, 0, 32'h6666);
    op("R6 sc again", 1, 32'h2000, 0, 32'h6767);
    op("R6 ll", 0, 32'h2000, 0, 0);
    op("R6 sc mismatch", 1, 32'h2008, 0, 32'h6868);
    op("R6 sc after fail", 1, 32'h2000, 0, 32'h6969);
    op("R7 ll", 0, 32'h2000, 0, 0);
    op("R7 sc collide", 1, 32'h2000, 0, 32'h7777, 1, 32'h2001);
    op("R7 ll", 0, 32'h2000, 0, 0);
    op("R7 sc other snoop", 1, 32'h2000, 0, 32'h7878, 0, 0, 1, 32'h2004);
    op("R8 ll collide", 0, 32'h2000, 0, 0, 0, 0, 1, 32'h2003);
    op("R8 sc", 1, 32'h2000, 0, 32'h8888);
    op("R11 ll a", 0, 32'h2000, 0, 0);
    op("R11 ll b", 0, 32'h3000, 0, 0);
    op("R11 sc a", 1, 32'h2000, 0, 32'hB1B1);
    op("R11 ll a", 0, 32'h2000, 0, 0);
    op("R11 ll b", 0, 32'h3000, 0, 0);
    op("R11 sc b", 1, 32'h3000, 0, 32'hB2B2);
    // R10 back-pressure
    op("R10 ll", 0, 32'h2000, 0, 0);
    @(negedge clk); resp_ready = 0;
    op("R10 sc", 1, 32'h2000, 0, 32'hA0A0);
    held = resp_data;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); #1;
      chk("R10 req_ready low", req_ready, 0);
      chk("R10 resp_valid held", resp_valid, 1);
      chk("R10 resp_data held", resp_data, held);
    end
    @(negedge clk); resp_ready = 1;
    @(posedge clk); #1;
    chk("R10 released", resp_valid, 0);
    // Random traffic in a narrow window
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] b, a0, a1;
      logic [OW-1:0] o;
      logic w0, w1;
      b  = 32'h1000 + ($urandom % 16);
      o  = OW'($signed($urandom % 17) - 8);
      a0 = 32'h0FF8 + ($urandom % 32);
      a1 = 32'h0FF8 + ($urandom % 32);
      w0 = ($urandom % 4) == 0;
      w1 = ($urandom % 4) == 0;
      case ($urandom % 3)
        0: op("R2 R5 R7 rnd ll", 0, b, o, 0, w0, a0, w1, a1);
        1: op("R2 R6 R7 rnd sc", 1, b, o, $urandom, w0, a0, w1, a1);
        default: idle("R5 rnd", w0, a0, w1, a1);
      endcase
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule